// File: doc/BRIEF.md
# Programmable Parallel Port Interface

This block is a bus-attached parallel I/O peripheral. An 8-bit processor bus reaches three 8-bit data ports and one write-only command register. The bus has an active-low chip select, an active-low read strobe, an active-low write strobe and a 2-bit register address. Ports A and B each switch between input and output as a whole. Port C is split into an upper and a lower 4-bit half, and each half chooses its direction on its own. Every port works in basic I/O. An output port drives its latch onto its pins. An input port is read straight from its pins.

The command address takes two kinds of word. A direction word sets the direction of the four port groups and clears every output latch. A bit command sets or clears a single port C latch bit, so software does not need a read-modify-write.

Writes take effect at the rising clock edge at which chip select and write are both low. Reads are combinational. The processor bus is modelled as a split input, output and output-enable triple, and each pin group has an output enable that stands for its tri-state buffer.

Top module: `ppio_top`

## Requirements
- R1: Address 0 selects port A, address 1 selects port B, address 2 selects port C and address 3 selects the command register. A write to a port address loads that port's latch and no other state.
- R2: While csN is high, no write changes any latch or direction, and the data bus output enable stays low.
- R3: dbOe is high only while csN and rdN are low, wrN is high and the address is 0, 1 or 2. A read at address 3 leaves the bus undriven, so the command register cannot be read back.
- R4: A command word with bit 7 set and bits 6, 5 and 2 clear is a direction word. A set bit makes its group an input: bit 4 for port A, bit 3 for the upper half of port C, bit 1 for port B and bit 0 for the lower half of port C. An output group has its pin enables (paOe, pbOe, pcOe bits) at 1.
- R5: A command word with bit 7 set and any of bits 6, 5 or 2 set is ignored. Directions and latches keep their values.
- R6: A valid direction word clears the port A, B and C latches to 0.
- R7: A command word with bit 7 clear is a bit command. Bits 3:1 give the port C bit index (0 to 7) and bit 0 gives its new value. Only that latch bit changes.
- R8: An output port drives its latch on its pin outputs, and a read of that port returns the latch.
- R9: A read of an input port, or of an input half of port C, returns the pin inputs present in that same cycle. For port C, the upper and lower halves are chosen independently.
- R10: A write, or a bit command, to an input group updates its latch (visible on paOut/pbOut/pcOut) but leaves that group's pin enables at 0.
- R11: After reset, every group is an input (all pin enables 0) and every latch is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| addr | input | 2 | Register address |
| dbIn | input | 8 | Processor write data |
| dbOut | output | 8 | Processor read data |
| dbOe | output | 1 | Processor data bus drive enable |
| paIn | input | 8 | Port A pin inputs |
| paOut | output | 8 | Port A latch value to pins |
| paOe | output | 1 | Port A pin drive enable |
| pbIn | input | 8 | Port B pin inputs |
| pbOut | output | 8 | Port B latch value to pins |
| pbOe | output | 1 | Port B pin drive enable |
| pcIn | input | 8 | Port C pin inputs |
| pcOut | output | 8 | Port C latch value to pins |
| pcOe | output | 8 | Port C per-pin drive enable |

## Verification
The bench puts port C into a mixed direction, with the upper half as input and the lower half as output. A design that chose the read source for the whole port would return pin data in the wrong half. It sends bit commands to low and high bit indices and checks the exact resulting byte. An off-by-one in the index field, or a design that rewrites the full latch, would disturb the other bits. It issues a direction word with a reserved bit set, which a lax decoder would accept, clearing latches and flipping directions. It also writes to input ports, reads the command address and writes with chip select high, where a faulty design would drive pins or the bus, or would accept the write.

// File: rtl/ppio_pkg.sv
package ppio_pkg;
  localparam int DATA_W = 8;
  localparam int HALF_W = DATA_W / 2;
  localparam int IDX_W  = $clog2(DATA_W);

  typedef enum logic [1:0] {
    SEL_A   = 2'd0,
    SEL_B   = 2'd1,
    SEL_C   = 2'd2,
    SEL_CMD = 2'd3
  } sel_e;

  typedef struct packed {
    logic wrA;
    logic wrB;
    logic wrC;
    logic modeWr;
    logic bsrWr;
    sel_e rdSel;
  } strobe_t;
endpackage

// File: rtl/ppio_ctl.sv
module ppio_ctl
  import ppio_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       rdN,
  input  logic       wrN,
  input  logic [1:0] addr,
  input  logic [3:0] cmdBits,   // {bit7, bit6, bit5, bit2} of the write data
  output strobe_t    strb,
  output logic       dbOe
);
  logic wrHit;
  logic cmdWr;
  logic rsvdClear;
  sel_e sel;

  assign sel       = sel_e'(addr);
  assign wrHit     = !csN && !wrN;
  assign cmdWr     = wrHit && (sel == SEL_CMD);
  assign rsvdClear = (cmdBits[2:0] == 3'b000);

  always_comb begin
    strb        = '0;
    strb.rdSel  = sel;
    strb.wrA    = wrHit && (sel == SEL_A);
    strb.wrB    = wrHit && (sel == SEL_B);
    strb.wrC    = wrHit && (sel == SEL_C);
    strb.modeWr = cmdWr && cmdBits[3] && rsvdClear;
    strb.bsrWr  = cmdWr && !cmdBits[3];
  end

  assign dbOe = !csN && !rdN && wrN && (sel != SEL_CMD);

  // R1: at most one register is written per cycle
  p_one_target_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrA, strb.wrB, strb.wrC, strb.modeWr, strb.bsrWr}));
endmodule

// File: rtl/ppio_dp.sv
module ppio_dp
  import ppio_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] dbIn,
  input  logic [DATA_W-1:0] paIn,
  input  logic [DATA_W-1:0] pbIn,
  input  logic [DATA_W-1:0] pcIn,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] paOut,
  output logic              paOe,
  output logic [DATA_W-1:0] pbOut,
  output logic              pbOe,
  output logic [DATA_W-1:0] pcOut,
  output logic [DATA_W-1:0] pcOe
);
  logic              dirA, dirB;   // 1 = input
  logic [1:0]        dirC;         // [1] upper half, [0] lower half
  logic [DATA_W-1:0] latA, latB, latC;
  logic [DATA_W-1:0] rdC;
  logic [IDX_W-1:0]  bitIdx;

  assign bitIdx = dbIn[IDX_W:1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirA <= 1'b1;
      dirB <= 1'b1;
      dirC <= 2'b11;
    end else if (strb.modeWr) begin
      dirA <= dbIn[4];
      dirC <= {dbIn[3], dbIn[0]};
      dirB <= dbIn[1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latA <= '0;
      latB <= '0;
      latC <= '0;
    end else if (strb.modeWr) begin
      latA <= '0;
      latB <= '0;
      latC <= '0;
    end else begin
      if (strb.wrA) latA <= dbIn;
      if (strb.wrB) latB <= dbIn;
      if (strb.wrC) latC <= dbIn;
      else if (strb.bsrWr) latC[bitIdx] <= dbIn[0];
    end
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign pcOe[h*HALF_W +: HALF_W] = {HALF_W{~dirC[h]}};
    assign rdC[h*HALF_W +: HALF_W]  = dirC[h] ? pcIn[h*HALF_W +: HALF_W]
                                              : latC[h*HALF_W +: HALF_W];
  end

  always_comb begin
    unique case (strb.rdSel)
      SEL_A:   rdData = dirA ? paIn : latA;
      SEL_B:   rdData = dirB ? pbIn : latB;
      SEL_C:   rdData = rdC;
      default: rdData = '0;
    endcase
  end

  assign paOut = latA;
  assign pbOut = latB;
  assign pcOut = latC;
  assign paOe  = ~dirA;
  assign pbOe  = ~dirB;

  // R6: a direction word leaves every latch at zero
  p_mode_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.modeWr |=> (latA == '0) && (latB == '0) && (latC == '0));

  // R7: a bit command alters at most one port C latch bit, and never A or B
  p_bsr_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.bsrWr |=> ($countones(latC ^ $past(latC)) <= 1) && $stable(latA) && $stable(latB));
endmodule

// File: rtl/ppio_top.sv
module ppio_top
  import ppio_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] dbIn,
  output logic [DATA_W-1:0] dbOut,
  output logic              dbOe,
  input  logic [DATA_W-1:0] paIn,
  output logic [DATA_W-1:0] paOut,
  output logic              paOe,
  input  logic [DATA_W-1:0] pbIn,
  output logic [DATA_W-1:0] pbOut,
  output logic              pbOe,
  input  logic [DATA_W-1:0] pcIn,
  output logic [DATA_W-1:0] pcOut,
  output logic [DATA_W-1:0] pcOe
);
  strobe_t strb;

  ppio_ctl u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .csN     (csN),
    .rdN     (rdN),
    .wrN     (wrN),
    .addr    (addr),
    .cmdBits ({dbIn[7], dbIn[6], dbIn[5], dbIn[2]}),
    .strb    (strb),
    .dbOe    (dbOe)
  );

  ppio_dp u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .dbIn   (dbIn),
    .paIn   (paIn),
    .pbIn   (pbIn),
    .pcIn   (pcIn),
    .rdData (dbOut),
    .paOut  (paOut),
    .paOe   (paOe),
    .pbOut  (pbOut),
    .pbOe   (pbOe),
    .pcOut  (pcOut),
    .pcOe   (pcOe)
  );

  // R2: without chip select, pin-side state holds
  p_no_cs_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> $stable(paOut) && $stable(pbOut) && $stable(pcOut)
            && $stable(paOe) && $stable(pbOe) && $stable(pcOe));

  // R3: the bus is driven only during a selected read
  p_bus_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    (csN || rdN) |-> !dbOe);
endmodule

// File: tb/ppio_top_tb_top.sv
module ppio_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       csN = 1'b1, rdN = 1'b1, wrN = 1'b1;
  logic [1:0] addr = 2'd0;
  logic [7:0] dbIn = 8'h00;
  logic [7:0] dbOut;
  logic       dbOe;
  logic [7:0] paIn = 8'h00, pbIn = 8'h00, pcIn = 8'h00;
  logic [7:0] paOut, pbOut, pcOut, pcOe;
  logic       paOe, pbOe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit rdActive = 1'b0;

  typedef struct {
    logic [7:0] data;
    logic       oe;
    string      tag;
  } exp_t;
  exp_t sbQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ppio_top dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .wrN(wrN), .addr(addr),
    .dbIn(dbIn), .dbOut(dbOut), .dbOe(dbOe),
    .paIn(paIn), .paOut(paOut), .paOe(paOe),
    .pbIn(pbIn), .pbOut(pbOut), .pbOe(pbOe),
    .pcIn(pcIn), .pcOut(pcOut), .pcOe(pcOe)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read results while a read is presented
  always @(negedge clk) begin
    if (rdActive && sbQ.size() > 0) begin
      exp_t e;
      e = sbQ.pop_front();
      chk({e.tag, " oe"}, {7'd0, dbOe}, {7'd0, e.oe});
      if (e.oe) chk({e.tag, " data"}, dbOut, e.data);
    end
  end

  task automatic busWrite(logic [1:0] a, logic [7:0] d, logic cs = 1'b0);
    @(posedge clk); #1;
    csN = cs; wrN = 1'b0; addr = a; dbIn = d;
    @(posedge clk); #1;
    csN = 1'b1; wrN = 1'b1;
  endtask

  task automatic busRead(logic [1:0] a, logic [7:0] expD, logic expOe,
                         string tag, logic cs = 1'b0);
    exp_t e;
    @(posedge clk); #1;
    csN = cs; rdN = 1'b0; addr = a;
    e.data = expD; e.oe = expOe; e.tag = tag;
    sbQ.push_back(e);
    rdActive = 1'b1;
    @(posedge clk); #1;
    rdActive = 1'b0;
    csN = 1'b1; rdN = 1'b1;
  endtask

  task automatic pinCheck(string tag, logic [7:0] act, logic [7:0] exp);
    @(negedge clk);
    chk(tag, act, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R11 reset state
    pinCheck("R11 oe", {pcOe[7:2], paOe, pbOe}, 8'h00);
    pinCheck("R11 pcOe", pcOe, 8'h00);
    pinCheck("R11 latches", paOut | pbOut | pcOut, 8'h00);

    // R3 command register is not readable
    busRead(2'd3, 8'h00, 1'b0, "R3 cmd read");
    // R2 no chip select: no drive, no write
    busRead(2'd0, 8'h00, 1'b0, "R2 read without cs", 1'b1);
    busWrite(2'd0, 8'hEE, 1'b1);
    pinCheck("R2 write without cs", paOut, 8'h00);

    // R4 all outputs
    busWrite(2'd3, 8'h80);
    pinCheck("R4 A/B oe", {6'd0, paOe, pbOe}, 8'h03);
    pinCheck("R4 pcOe", pcOe, 8'hFF);

    // R1 / R8 writes and read back
    busWrite(2'd0, 8'h5A);
    busWrite(2'd1, 8'hC3);
    busWrite(2'd2, 8'h96);
    pinCheck("R8 paOut", paOut, 8'h5A);
    pinCheck("R1 pbOut", pbOut, 8'hC3);
    busRead(2'd0, 8'h5A, 1'b1, "R8 read A");
    busRead(2'd1, 8'hC3, 1'b1, "R1 read B");
    busRead(2'd2, 8'h96, 1'b1, "R1 read C");

    // R7 bit commands
    busWrite(2'd3, 8'h01);              // bit 0 <- 1
    pinCheck("R7 set bit0", pcOut, 8'h97);
    busWrite(2'd3, 8'h08);              // bit 4 <- 0
    pinCheck("R7 clear bit4", pcOut, 8'h87);
    busWrite(2'd3, 8'h0E);              // bit 7 <- 0
    pinCheck("R7 clear bit7", pcOut, 8'h07);
    pinCheck("R7 A untouched", paOut, 8'h5A);

    // R6 direction word clears latches
    busWrite(2'd3, 8'h80);
    pinCheck("R6 A cleared", paOut, 8'h00);
    pinCheck("R6 C cleared", pcOut | pbOut, 8'h00);

    // R9 / R10 mixed port C: upper input, lower output
    busWrite(2'd3, 8'h88);
    pinCheck("R4 pcOe mixed", pcOe, 8'h0F);
    pcIn = 8'hA5;
    busWrite(2'd2, 8'h3C);
    busRead(2'd2, 8'hAC, 1'b1, "R9 C halves");
    pinCheck("R10 pcOut latch", pcOut, 8'h3C);
    pinCheck("R10 pcOe held", pcOe, 8'h0F);
    busWrite(2'd3, 8'h0F);              // bit 7 <- 1, input half
    pinCheck("R10 bsr input half", pcOut, 8'hBC);

    // R9 / R10 ports A and B inputs
    busWrite(2'd3, 8'h92);
    pinCheck("R4 A/B inputs", {6'd0, paOe, pbOe}, 8'h00);
    paIn = 8'h77; pbIn = 8'h3E;
    busRead(2'd0, 8'h77, 1'b1, "R9 read A pins");
    busRead(2'd1, 8'h3E, 1'b1, "R9 read B pins");
    busWrite(2'd0, 8'h11);
    pinCheck("R10 paOut latch", paOut, 8'h11);
    pinCheck("R10 paOe held", {7'd0, paOe}, 8'h00);

    // R5 reserved bits make the word ignored
    busWrite(2'd3, 8'hA0);
    pinCheck("R5 latch kept", paOut, 8'h11);
    pinCheck("R5 pcOe kept", pcOe, 8'hFF);
    busWrite(2'd3, 8'h84);
    pinCheck("R5 A/B dir kept", {6'd0, paOe, pbOe}, 8'h00);

    repeat (2) @(posedge clk);
    if (sbQ.size() != 0) begin
      errors++;
      $display("FAIL scoreboard leftover %0d expected 0", sbQ.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule